// File: doc/BRIEF.md
# Double-Width Funnel Shifter with Flags

This unit joins a destination word and a source word into one double-width value. It shifts that value left or right and returns the destination-sized slice. In a left shift the source's high bits fill the vacated low end of the destination. In a right shift the source's low bits fill the vacated high end. The shift distance comes either from an 8-bit immediate field or from an 8-bit count register, and an opcode bit selects which one. Only the low five bits of the selected value are used.

A strobe on `valid_i` samples all inputs. One cycle later the unit raises a single-cycle `done_o`, and with it a registered result, a write-enable and the six arithmetic flags. A masked count of zero is a no-op: the write-enable stays low, and the result and flags keep their earlier values.

Top module: `funnel_shift_unit`

## Requirements
- R1: The effective count n is the low 5 bits of the selected count source. `opcode_i[0]`=0 selects `imm_i` and `opcode_i[0]`=1 selects `cnt_reg_i`; the unselected field has no effect.
- R2: With `opcode_i[1]`=0 (left) and n>0, the result is (dst << n) | (src >> (32-n)).
- R3: With `opcode_i[1]`=1 (right) and n>0, the result is (src << (32-n)) | (dst >> n).
- R4: When n=0, `wr_en_o` stays low, and `result_o` and `flags_o` keep their previous values.
- R5: For n>0, C (`flags_o[0]`) is the last bit shifted out of dst: dst[32-n] for left shifts and dst[n-1] for right shifts.
- R6: For n>0, S (`flags_o[4]`) is result[31], Z (`flags_o[3]`) is set when the result is zero, P (`flags_o[1]`) is set when result[7:0] has an even number of ones, and A (`flags_o[2]`) is cleared.
- R7: For n>0, O (`flags_o[5]`) is result[31] XOR C for left shifts and dst[31] XOR result[31] for right shifts, for every count.
- R8: `done_o` is high exactly in the cycle after each cycle in which `valid_i` is high. `wr_en_o` is high in that same cycle only when n>0.
- R9: While `rst_ni` is low, `result_o`, `flags_o`, `wr_en_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| opcode_i | input | 2 | Bit 1: direction (1 = right); bit 0: count source (1 = count register) |
| imm_i | input | 8 | Immediate count field |
| cnt_reg_i | input | 8 | Count register value |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand supplying fill bits |
| result_o | output | 32 | Registered shift result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 6 | {O, S, Z, A, P, C} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives counts whose upper bits are set, such as 37 and 0xE3. A unit that fails to mask would shift too far, and one that compares the raw byte against zero would take 32 or 64 for a real shift instead of a no-op. Counts of 1 and 31 exercise the ends of the C and O index arithmetic, where an off-by-one picks the wrong destination bit. Zero-count strobes come after a real shift, so a unit that writes or refreshes flags anyway shows changed flags or a spurious write-enable. Mixed immediate and register values catch a swapped count-source select.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic {DIR_LEFT = 1'b0, DIR_RIGHT = 1'b1} fsh_dir_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } fsh_flags_t;
endpackage

// File: rtl/fsh_count_sel.sv
module fsh_count_sel #(
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 5
) (
  input  logic [FIELD_W-1:0] imm_i,
  input  logic [FIELD_W-1:0] reg_i,
  input  logic               use_reg_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [FIELD_W-1:0] raw;
  assign raw   = use_reg_i ? reg_i : imm_i;
  // keep only the low bits: count wraps modulo the word width
  assign cnt_o = CNT_W'(raw);
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel
  import fsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     src_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  fsh_dir_e         dir_i,
  output logic [W-1:0]     res_o,
  output logic             cf_o
);
  logic [W-1:0]     res_l, res_r;
  logic [CNT_W-1:0] idx_l, idx_r;

  assign res_l = W'(({dst_i, src_i} << cnt_i) >> W);
  assign res_r = W'({src_i, dst_i} >> cnt_i);

  // last bit leaving dst; index wraps harmlessly when cnt is zero
  assign idx_l = CNT_W'(W - int'(cnt_i));
  assign idx_r = cnt_i - CNT_W'(1);

  always_comb begin
    if (dir_i == DIR_LEFT) begin
      res_o = res_l;
      cf_o  = dst_i[idx_l];
    end else begin
      res_o = res_r;
      cf_o  = dst_i[idx_r];
    end
  end
endmodule

// File: rtl/fsh_flag_gen.sv
module fsh_flag_gen
  import fsh_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         dst_msb_i,
  input  logic         cf_i,
  input  fsh_dir_e     dir_i,
  output fsh_flags_t   flags_o
);
  always_comb begin
    flags_o.cf = cf_i;
    flags_o.sf = res_i[W-1];
    flags_o.zf = (res_i == '0);
    flags_o.af = 1'b0;
    flags_o.pf = ~^res_i[7:0];
    flags_o.of = (dir_i == DIR_LEFT) ? (res_i[W-1] ^ cf_i)
                                     : (dst_msb_i ^ res_i[W-1]);
  end
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
  import fsh_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         opcode_i,
  input  logic [FIELD_W-1:0] imm_i,
  input  logic [FIELD_W-1:0] cnt_reg_i,
  input  logic [WIDTH-1:0]   dst_i,
  input  logic [WIDTH-1:0]   src_i,
  output logic [WIDTH-1:0]   result_o,
  output logic               wr_en_o,
  output logic [5:0]         flags_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(WIDTH);

  fsh_dir_e         dir;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] res_d;
  logic             cf_d;
  fsh_flags_t       flags_d, flags_q;
  logic [WIDTH-1:0] res_q;
  logic             wr_q, done_q;
  logic             take;

  assign dir = fsh_dir_e'(opcode_i[1]);

  fsh_count_sel #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_cnt (
    .imm_i    (imm_i),
    .reg_i    (cnt_reg_i),
    .use_reg_i(opcode_i[0]),
    .cnt_o    (cnt)
  );

  fsh_funnel #(.W(WIDTH), .CNT_W(CNT_W)) u_funnel (
    .dst_i(dst_i),
    .src_i(src_i),
    .cnt_i(cnt),
    .dir_i(dir),
    .res_o(res_d),
    .cf_o (cf_d)
  );

  fsh_flag_gen #(.W(WIDTH)) u_flags (
    .res_i    (res_d),
    .dst_msb_i(dst_i[WIDTH-1]),
    .cf_i     (cf_d),
    .dir_i    (dir),
    .flags_o  (flags_d)
  );

  assign take = valid_i && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= valid_i;
      wr_q   <= take;
      if (take) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign result_o = res_q;
  assign flags_o  = flags_q;
  assign wr_en_o  = wr_q;
  assign done_o   = done_q;
endmodule

// File: rtl/funnel_shift_unit_chk.sv
module funnel_shift_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [WIDTH-1:0] result_o,
  input logic             wr_en_o,
  input logic [5:0]       flags_o,
  input logic             done_o
);
  // R8
  done_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R8
  done_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));
  // R8
  wr_within_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);
  // R4
  hold_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> $stable({result_o, flags_o}));
  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (flags_o[3] == (result_o == '0)));
  // R6
  sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (flags_o[4] == result_o[WIDTH-1]));
  // R6
  parity_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (flags_o[1] == ~^result_o[7:0]));
  // R6
  aux_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[2]);
endmodule

bind funnel_shift_unit funnel_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .result_o(result_o),
  .wr_en_o (wr_en_o),
  .flags_o (flags_o),
  .done_o  (done_o)
);

// File: tb/sim_funnel_shift_unit.sv
`timescale 1ns/1ps
module sim_funnel_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  opcode_i = '0;
  logic [7:0]  imm_i = '0, cnt_reg_i = '0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o, done_o;
  logic [5:0]  flags_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_res = '0;
  logic [5:0]  exp_flg = '0;

  always #2.5 clk_i = ~clk_i;

  funnel_shift_unit u0 (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  imm;
    logic [7:0]  cnt;
    logic [31:0] dst;
    logic [31:0] src;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 8'd4,   8'd0,   32'h12345678, 32'h9ABCDEF0}, // R2 imm
    '{2'b10, 8'd8,   8'd0,   32'h12345678, 32'hCAFEBABE}, // R3 imm
    '{2'b01, 8'd0,   8'd1,   32'h80000000, 32'h00000000}, // R5 R6 left n=1 zero
    '{2'b11, 8'd0,   8'd1,   32'h00000001, 32'h00000000}, // R5 right n=1
    '{2'b00, 8'd31,  8'd0,   32'hFFFFFFFF, 32'h00000000}, // R5 left n=31
    '{2'b10, 8'd31,  8'd0,   32'h7FFFFFFF, 32'hAAAAAAAB}, // R5 right n=31
    '{2'b01, 8'd0,   8'd37,  32'hDEADBEEF, 32'h01234567}, // R1 reg 37->5
    '{2'b10, 8'hE3,  8'd0,   32'hF0F0F0F0, 32'h0000000F}, // R1 imm E3->3
    '{2'b00, 8'd32,  8'd7,   32'h11111111, 32'h22222222}, // R4 imm 32->0
    '{2'b11, 8'd5,   8'h40,  32'h33333333, 32'h44444444}, // R4 reg 64->0
    '{2'b00, 8'd1,   8'd0,   32'h40000000, 32'h00000000}, // R7 left OF
    '{2'b10, 8'd1,   8'd0,   32'h80000000, 32'h00000001}, // R7 right OF
    '{2'b01, 8'd0,   8'd3,   32'h0000F00F, 32'hE0000000}, // R1 reg, imm ignored
    '{2'b00, 8'd3,   8'd0,   32'h0000F00F, 32'hE0000000}  // R1 imm, reg ignored
  };

  // bit-serial reference, built from R1-style masking and R2..R7
  task automatic model(input logic [1:0] op, input logic [7:0] imm,
                       input logic [7:0] cnt, input logic [31:0] dst,
                       input logic [31:0] src, output logic wr);
    int          n;
    logic [31:0] d, s;
    logic        c, par;
    n = op[0] ? int'(cnt % 32) : int'(imm % 32);
    wr = (n != 0);
    if (!wr) return;
    d = dst; s = src; c = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (!op[1]) begin
        c = d[31]; d = {d[30:0], s[31]}; s = s << 1;
      end else begin
        c = d[0];  d = {s[0], d[31:1]};  s = s >> 1;
      end
    end
    par = 1'b1;
    for (int b = 0; b < 8; b++) par = par ^ d[b];
    exp_res = d;
    exp_flg = {(op[1] ? (dst[31] ^ d[31]) : (d[31] ^ c)),
               d[31], (d == 32'h0), 1'b0, par, c};
  endtask

  task automatic check(input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    logic wr;
    @(negedge clk_i);
    opcode_i = v.op; imm_i = v.imm; cnt_reg_i = v.cnt;
    dst_i = v.dst; src_i = v.src; valid_i = 1'b1;
    model(v.op, v.imm, v.cnt, v.dst, v.src, wr);
    @(negedge clk_i);
    check("R1/R2/R3/R4/R5/R6/R7/R8", {done_o, wr_en_o, result_o, flags_o},
          {1'b1, wr, exp_res, exp_flg});
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state
    #7;
    check("R9", {done_o, wr_en_o, result_o, flags_o}, 40'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 idle", {38'h0, done_o, wr_en_o}, 40'h0);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R8: done drops after valid goes low, outputs held (R4)
    @(negedge clk_i);
    valid_i = 1'b0; imm_i = 8'd9; dst_i = 32'hFFFF0000;
    @(negedge clk_i);
    check("R8 done pulse", {done_o, wr_en_o, result_o, flags_o},
          {2'b00, exp_res, exp_flg});

    // R4 zero count right after a real shift keeps the flags
    apply('{2'b10, 8'd2, 8'd0, 32'h00000003, 32'h00000000});
    apply('{2'b00, 8'd0, 8'd9, 32'hFFFFFFFF, 32'hFFFFFFFF});

    // R9 reset mid-run clears outputs
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R9 mid-run", {done_o, wr_en_o, result_o, flags_o}, 40'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_res = '0; exp_flg = '0;
    apply('{2'b01, 8'd3, 8'd0, 32'h12345678, 32'h0});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule